// File: doc/BRIEF.md
# System Clock Source Selector

This block picks which of three clock sources drives the system: the raw input clock, a PLL-multiplied clock, or a divided version of the input clock. All three are modelled as clock enables on a single fast reference clock. The PLL clock is the reference itself. The input clock appears as one `in_tick` pulse per input period. The divided clock is every r-th input tick, where r is the programmed ratio. The output `sys_ce` is the gated enable stream that the rest of the chip treats as its system clock.

Software selects the source and ratio by writing a control word. A processor halt request moves the system onto the divided clock. A wake request brings it back to the source it was on before the halt.

Every change of source inserts a stretched high phase. During this phase no enable pulse is issued, so no runt clock can reach downstream logic. Its length depends on whether the change is toward a faster or a slower source. An accepted configuration write is followed by a settling window, counted in system clock pulses, during which `busy` stays high and further writes are refused. A wake request that arrives during or together with a halt entry is held until the entry completes, so a halted system always restarts.

Top module: `sysclk_mux`

## Requirements
- R1: After reset the source is the input clock (`src_now`=0), the ratio is 1, and `halted`, `busy`, `stretch` and `sys_ce` are all low.
- R2: Source codes are 0 = input clock, 1 = PLL clock, 2 = divided clock. With no stretch in progress, `sys_ce` is high in the cycle after a tick of the selected source:
  - the PLL source ticks every cycle;
  - the input source ticks on every `in_tick`;
  - the divided source ticks on every r-th `in_tick`, and a ratio of 0 acts as 1.
- R3: The speed order, fastest first, is PLL, input, divided. A change toward a faster source raises `stretch` for exactly 2·r+5 cycles, where r is the ratio in effect after the change. This is the 2·r+4.5 rule rounded up to whole reference cycles.
- R4: A change toward a slower source raises `stretch` for exactly 8·r+1 cycles.
- R5: In any cycle that follows a cycle with `stretch` high, `sys_ce` is low.
- R6: An accepted write raises `busy` from the next cycle. `busy` stays high until the stretch has ended and 16 `sys_ce` pulses have been counted since the write.
- R7: A write is ignored, leaving `src_now` and the timing unchanged, in any of these cases: `busy` is high, `halted` is high, a halt request is taken in the same cycle, or the source code is 3.
- R8: A halt request taken while not halted and not stretching switches to the divided source and sets `halted`. From a non-divided source this is a slower change, with the R4 stretch using the current ratio. From the divided source there is no stretch.
- R9: A wake request while halted returns to the source in use before the halt, with the stretch that R3 or R4 gives for that change. A wake arriving during the entry stretch, or in the same cycle as the halt request, is held and acted on as soon as the stretch ends. A wake while not halted, and a halt request while halted or stretching, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (PLL rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_tick | input | 1 | One pulse per period of the raw input clock |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_src | input | 2 | Requested source code |
| cfg_ratio | input | RATIO_W | Divide ratio for the divided source |
| halt_req | input | 1 | Processor halt request pulse |
| wake_req | input | 1 | Interrupt wake request pulse |
| sys_ce | output | 1 | System clock enable stream |
| stretch | output | 1 | Regulating high phase in progress |
| busy | output | 1 | Stretch or settling window in progress |
| halted | output | 1 | Halt mode active |
| src_now | output | 2 | Source currently in use |

## Verification
The assertions assume that `src_now` moves only through the three legal codes, and that a write, halt or wake has its effect one reference cycle after it is sampled. The stimulus drives all inputs half a cycle away from the active edge and holds each strobe for one cycle. Input tick density is varied across several bands so that the settling window completes on every source. Halt and wake pulses are sparse, with directed cases that put a wake in the same cycle as a halt and during the entry stretch.

// File: rtl/sysclk_mux_pkg.sv
`timescale 1ns/1ps
package sysclk_mux_pkg;

    typedef enum logic [1:0] {
        SRC_IN  = 2'd0,
        SRC_PLL = 2'd1,
        SRC_DIV = 2'd2,
        SRC_BAD = 2'd3
    } src_e;

    // Lower rank means a faster clock.
    function automatic int unsigned speed_rank(src_e s);
        case (s)
            SRC_PLL: return 0;
            SRC_IN:  return 1;
            default: return 2;
        endcase
    endfunction

    // Length of the regulating high phase, in reference cycles.
    function automatic int unsigned reg_len(src_e from_s, src_e to_s, int unsigned r);
        if (from_s == to_s) return 0;
        if (speed_rank(to_s) < speed_rank(from_s)) return 2 * r + 5;
        return 8 * r + 1;
    endfunction

endpackage

// File: rtl/sysclk_mux_div.sv
`timescale 1ns/1ps
module sysclk_mux_div #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_tick,
    input  logic [RATIO_W-1:0] ratio,
    output logic               div_tick
);
    logic [RATIO_W-1:0] cnt_d, cnt_q;
    logic [RATIO_W-1:0] eff_m1;
    logic               wrap;

    always_comb begin
        eff_m1   = (ratio == '0) ? '0 : ratio - 1'b1;
        wrap     = (cnt_q >= eff_m1);
        div_tick = in_tick && wrap;
        cnt_d    = cnt_q;
        if (in_tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sysclk_mux_down.sv
`timescale 1ns/1ps
module sysclk_mux_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         nz
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = load_val;
        else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
    assign nz  = (cnt_q != '0);
endmodule

// File: rtl/sysclk_mux.sv
`timescale 1ns/1ps
module sysclk_mux
    import sysclk_mux_pkg::*;
#(
    parameter int RATIO_W = 4,
    parameter int SETTLE  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_tick,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_src,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               halt_req,
    input  logic               wake_req,
    output logic               sys_ce,
    output logic               stretch,
    output logic               busy,
    output logic               halted,
    output logic [1:0]         src_now
);
    localparam int RATIO_MAX = (1 << RATIO_W) - 1;
    localparam int STR_W     = $clog2(8 * RATIO_MAX + 2);
    localparam int SET_W     = $clog2(SETTLE + 1);

    typedef struct packed {
        src_e               src;
        src_e               saved;
        logic [RATIO_W-1:0] ratio;
        logic               halted;
        logic               wake;
        logic               ce;
    } state_t;

    state_t st_d, st_q;

    logic             div_tick, tick;
    logic [STR_W-1:0] str_cnt, str_val;
    logic [SET_W-1:0] set_cnt;
    logic             str_nz, set_nz, str_load, set_load;
    src_e             cfg_sel;

    assign cfg_sel = src_e'(cfg_src);

    function automatic int unsigned eff_ratio(logic [RATIO_W-1:0] r);
        return (r == '0) ? 1 : int'(r);
    endfunction

    sysclk_mux_div #(.RATIO_W(RATIO_W)) u_div (
        .clk(clk), .rst_n(rst_n), .in_tick(in_tick),
        .ratio(st_q.ratio), .div_tick(div_tick)
    );

    sysclk_mux_down #(.W(STR_W)) u_stretch (
        .clk(clk), .rst_n(rst_n), .load(str_load), .load_val(str_val),
        .dec(1'b1), .cnt(str_cnt), .nz(str_nz)
    );

    sysclk_mux_down #(.W(SET_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(set_load), .load_val(SET_W'(SETTLE)),
        .dec(st_d.ce), .cnt(set_cnt), .nz(set_nz)
    );

    always_comb begin
        st_d     = st_q;
        str_load = 1'b0;
        str_val  = '0;
        set_load = 1'b0;

        case (st_q.src)
            SRC_PLL: tick = 1'b1;
            SRC_IN:  tick = in_tick;
            default: tick = div_tick;
        endcase
        st_d.ce = !str_nz && tick;

        if (!str_nz && st_q.halted && (st_q.wake || wake_req)) begin
            // leave halt toward the remembered source
            st_d.src    = st_q.saved;
            st_d.halted = 1'b0;
            st_d.wake   = 1'b0;
            str_load    = 1'b1;
            str_val     = STR_W'(reg_len(SRC_DIV, st_q.saved, eff_ratio(st_q.ratio)));
        end else if (!str_nz && !st_q.halted && halt_req) begin
            st_d.saved  = st_q.src;
            st_d.src    = SRC_DIV;
            st_d.halted = 1'b1;
            st_d.wake   = wake_req;
            str_load    = 1'b1;
            str_val     = STR_W'(reg_len(st_q.src, SRC_DIV, eff_ratio(st_q.ratio)));
        end else begin
            if (st_q.halted && wake_req) st_d.wake = 1'b1;
            if (!st_q.halted && cfg_wr && !str_nz && !set_nz && cfg_sel != SRC_BAD) begin
                st_d.src   = cfg_sel;
                st_d.ratio = cfg_ratio;
                str_load   = 1'b1;
                str_val    = STR_W'(reg_len(st_q.src, cfg_sel, eff_ratio(cfg_ratio)));
                set_load   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src    <= SRC_IN;
            st_q.saved  <= SRC_IN;
            st_q.ratio  <= RATIO_W'(1);
            st_q.halted <= 1'b0;
            st_q.wake   <= 1'b0;
            st_q.ce     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_ce  = st_q.ce;
    assign stretch = str_nz;
    assign busy    = str_nz || set_nz;
    assign halted  = st_q.halted;
    assign src_now = st_q.src;
endmodule

// File: rtl/sysclk_mux_chk.sv
`timescale 1ns/1ps
module sysclk_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       halt_req,
    input logic       sys_ce,
    input logic       stretch,
    input logic       busy,
    input logic       halted,
    input logic [1:0] src_now
);
    // R5
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> !sys_ce);

    // R3
    switch_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_now != $past(src_now)) |-> stretch);

    // R8
    halt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (src_now == 2'd2));

    // R7
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && busy && !halted && !halt_req) |=> $stable(src_now));

    // R6
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> busy);

    // R2
    legal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_now != 2'd3);
endmodule

bind sysclk_mux sysclk_mux_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .halt_req(halt_req),
    .sys_ce(sys_ce), .stretch(stretch), .busy(busy), .halted(halted),
    .src_now(src_now)
);

// File: tb/sysclk_mux_test.sv
`timescale 1ns/1ps
module sysclk_mux_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_tick = 1'b0, cfg_wr = 1'b0, halt_req = 1'b0, wake_req = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic [3:0] cfg_ratio = 4'd1;
    logic       sys_ce, stretch, busy, halted;
    logic [1:0] src_now;

    int errors = 0, checks = 0, cycles = 0;
    int run = 0, last_run = 0;
    // bench model state
    int m_src = 0, m_saved = 0, m_ratio = 1, m_halted = 0, m_wake = 0;
    int m_ce = 0, m_str = 0, m_set = 0, m_div = 0;

    always #2 clk = ~clk; // 250 MHz

    sysclk_mux uut (
        .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .cfg_wr(cfg_wr),
        .cfg_src(cfg_src), .cfg_ratio(cfg_ratio), .halt_req(halt_req),
        .wake_req(wake_req), .sys_ce(sys_ce), .stretch(stretch), .busy(busy),
        .halted(halted), .src_now(src_now)
    );

    function automatic int rank(int s);
        if (s == 1) return 0;
        if (s == 0) return 1;
        return 2;
    endfunction

    function automatic int blen(int f, int t, int r);
        if (f == t) return 0;
        return (rank(t) < rank(f)) ? 2 * r + 5 : 8 * r + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_step();
        int er, dt, nd, tk, nce, nstr, nset;
        er  = (m_ratio == 0) ? 1 : m_ratio;
        dt  = (in_tick && m_div >= er - 1) ? 1 : 0;
        nd  = in_tick ? (dt ? 0 : m_div + 1) : m_div;
        tk  = (m_src == 1) ? 1 : (m_src == 0) ? int'(in_tick) : dt;
        nce = (m_str == 0 && tk) ? 1 : 0;
        nstr = (m_str > 0) ? m_str - 1 : 0;
        nset = (m_set > 0 && nce) ? m_set - 1 : m_set;
        if (m_str == 0 && m_halted && (m_wake || wake_req)) begin
            nstr = blen(2, m_saved, er);
            m_src = m_saved; m_halted = 0; m_wake = 0;
        end else if (m_str == 0 && !m_halted && halt_req) begin
            nstr = blen(m_src, 2, er);
            m_saved = m_src; m_src = 2; m_halted = 1; m_wake = int'(wake_req);
        end else begin
            if (m_halted && wake_req) m_wake = 1;
            if (!m_halted && cfg_wr && m_str == 0 && m_set == 0 && cfg_src != 2'd3) begin
                nstr = blen(m_src, int'(cfg_src), (cfg_ratio == 0) ? 1 : int'(cfg_ratio));
                nset = 16;
                m_src = int'(cfg_src); m_ratio = int'(cfg_ratio);
            end
        end
        m_ce = nce; m_str = nstr; m_set = nset; m_div = nd;
    endtask

    // one cycle: compare at negedge, drive, advance model
    task automatic cyc(logic it, logic wr, logic [1:0] s, logic [3:0] r, logic h, logic w);
        @(negedge clk);
        chk("R2 sys_ce", int'(sys_ce), m_ce);
        chk("R3/R4 stretch", int'(stretch), int'(m_str != 0));
        chk("R6 busy", int'(busy), int'(m_str != 0 || m_set != 0));
        chk("R8/R9 halted", int'(halted), m_halted);
        chk("R7 src_now", int'(src_now), m_src);
        in_tick = it; cfg_wr = wr; cfg_src = s; cfg_ratio = r; halt_req = h; wake_req = w;
        model_step();
    endtask

    task automatic settle_wait();
        for (int k = 0; k < 400 && (m_str != 0 || m_set != 0); k++) cyc(1, 0, 0, 0, 0, 0);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (stretch) run++;
            else if (run > 0) begin last_run = run; run = 0; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dens;
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 src", int'(src_now), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 stretch", int'(stretch), 0);
        chk("R1 sys_ce", int'(sys_ce), 0);

        // R3: input -> PLL, ratio 3 gives 11 cycles
        cyc(1, 1, 2'd1, 4'd3, 0, 0);
        cyc(1, 1, 2'd2, 4'd5, 0, 0); // R7: write while busy
        settle_wait();
        cyc(1, 0, 0, 0, 0, 0);
        chk("R3 stretch length", last_run, 11);
        chk("R7 busy write dropped", int'(src_now), 1);

        // R4: PLL -> divided, ratio 2 gives 17 cycles
        cyc(1, 1, 2'd2, 4'd2, 0, 0);
        settle_wait();
        cyc(1, 0, 0, 0, 0, 0);
        chk("R4 stretch length", last_run, 17);

        // R7: code 3 ignored
        cyc(1, 1, 2'd3, 4'd7, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R7 code3 src", int'(src_now), 2);
        chk("R7 code3 busy", int'(busy), 0);

        // R2: ratio 0 acts as 1 on the divided source
        cyc(1, 1, 2'd2, 4'd0, 0, 0);
        settle_wait();
        for (int k = 0; k < 20; k++) cyc(k % 3 == 0, 0, 0, 0, 0, 0);

        // back to PLL, then R9: halt and wake in the same cycle
        cyc(1, 1, 2'd1, 4'd2, 0, 0);
        settle_wait();
        cyc(1, 0, 0, 0, 1, 1);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R8 halt entered", int'(halted), 1);
        for (int k = 0; k < 60; k++) cyc(1, 0, 0, 0, 0, 0);
        chk("R9 wake held", int'(halted), 0);
        chk("R9 source back", int'(src_now), 1);
        chk("R8/R9 last stretch", last_run, 9);

        // R9: wake while not halted has no effect
        cyc(1, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R9 stray wake", int'(halted), 0);

        // random phase
        dens = 50;
        for (int i = 0; i < 8000; i++) begin
            if (i % 500 == 0) dens = $urandom_range(5, 100);
            cyc($urandom_range(0, 99) < dens,
                $urandom_range(0, 99) < 6,
                2'($urandom_range(0, 3)),
                4'($urandom_range(0, 15)),
                $urandom_range(0, 199) < 2,
                $urandom_range(0, 99) < 2);
        end
        cyc(0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule